// File: doc/BRIEF.md
# Synchronizable Up-Down PWM Timebase

This block is the time-base counter of one PWM channel. It counts up from zero to a programmed period and back down to zero, so every PWM cycle holds one zero point and one period point. Each point raises a one-clock event pulse. Two start-of-conversion channels can each turn one of these events into a trigger for an ADC. A power-of-two prescaler sets how often the counter moves.

Several timebases can be chained. A master passes a synchronization pulse to its slaves. A slave with phase loading enabled jumps to its phase value when that pulse arrives. The period is written into a shadow copy. The copy takes effect when the counter leaves zero and also on every sync pulse, so a period change never alters a cycle already in progress. A sync load that puts the counter at zero still raises the zero event. The zero event is raised once only when the counter was already sitting at zero. Because of this, a slave that is retimed every cycle keeps a one-to-one ratio between zero triggers and period triggers.

Top module: `pwm_timebase`

## Requirements
- R1: During and just after reset the counter reads 0, the direction is up (dirUp=1), and zeroEvt, periodEvt, socPulse, syncOut, ctrMaxFlag and syncFlag are all 0.
- R2: With cfgClkDiv=0 and an active period P of 1 or more, the counter starting from 0 rises by one per clock up to P, then falls by one per clock down to 0, so one cycle lasts 2P clocks.
- R3: periodEvt is high for exactly the one clock in which the counter shows P after an up step. zeroEvt is high for exactly the one clock in which the counter shows 0 after a down step.
- R4: cfgPeriod is copied into the active period when a count step leaves zero and on every syncIn pulse. A change to cfgPeriod in the middle of a cycle leaves the running cycle untouched.
- R5: With cfgClkDiv=d the counter steps once every 2^d clocks. The first step comes 2^d clocks after reset, after a counter write, or after a phase load.
- R6: A syncIn pulse with cfgPhaseEn=1 loads cfgPhase into the counter at the next edge and overrides the count step. With cfgPhaseEn=0 the pulse leaves the counter running.
- R7: After a phase load the direction is up, whichever way the counter was moving before.
- R8: cfgSyncOutSel picks what drives syncOut. 0 gives syncIn delayed by one clock. 1 gives a pulse in the same clock as zeroEvt. 2 and 3 hold syncOut low.
- R9: A phase load that puts the counter at 0 from a nonzero value raises zeroEvt. A phase load of 0 while the counter already reads 0 raises no event. zeroEvt is never high on two consecutive clocks.
- R10: Channel i of socPulse uses the select bits socSel[2i+1:2i]. The value 01 picks the zero event and 10 picks the period event. The values 00 and 11 pick nothing. socEn[i]=0 blocks the channel.
- R11: ctrMaxFlag is set when a step takes the counter up to all ones. syncFlag is set by syncIn. Writing 1 to statusClr[0] clears ctrMaxFlag, and writing 1 to statusClr[1] clears syncFlag. A set in the same clock as a clear wins.
- R12: ctrWrEn loads ctrWrData into the counter at the next edge. It takes priority over sync and step, keeps the direction unchanged and raises no event.
- R13: Take a slave with phase 0, fed from a master whose syncOut is set to its zero event, with both using the same period. Over many cycles, and while that period changes mid-run, each one produces alternating zero and period events in equal numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgPeriod | input | CNT_W | Shadow period value |
| cfgPhase | input | CNT_W | Value loaded on sync |
| cfgPhaseEn | input | 1 | Enables loading the phase value on sync |
| cfgSyncOutSel | input | 2 | Source select for syncOut |
| cfgClkDiv | input | DIV_W | Prescaler exponent, divide by 2^value |
| socEn | input | SOC_CH | Enable per start-of-conversion channel |
| socSel | input | 2*SOC_CH | Event select per channel |
| ctrWrEn | input | 1 | Direct counter write strobe |
| ctrWrData | input | CNT_W | Value for the direct write |
| statusClr | input | 2 | Write-1-to-clear for the flags |
| syncIn | input | 1 | Synchronization pulse in |
| counter | output | CNT_W | Current count |
| dirUp | output | 1 | 1 while counting up |
| zeroEvt | output | 1 | Zero-point event pulse |
| periodEvt | output | 1 | Period-point event pulse |
| socPulse | output | SOC_CH | Start-of-conversion pulses |
| syncOut | output | 1 | Synchronization pulse to the next timebase |
| ctrMaxFlag | output | 1 | Sticky flag: counter reached all ones |
| syncFlag | output | 1 | Sticky flag: sync received |

## Verification
The assertions check these rules on every clock: an event pulse matches the counter value it stands for, the counter moves by at most one unless it is written or phase-loaded, a load places the phase value and sets the direction up, syncOut follows the selected source, and no zero pulse comes twice in a row. Other behaviours only the bench scenarios can show. These are the exact sequence of counts, the shadow period taking effect only at the next cycle start, the prescaler spacing, and set-over-clear on the flags. The most important of these is the master and slave chain run with a period changed during the run, which shows that a sync load at zero keeps the zero and period trigger counts equal.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;

  // strobes from control to datapath, at most one of wr/load/step at a time
  typedef struct packed {
    logic wr;      // direct counter write
    logic load;    // phase load from sync
    logic shadow;  // copy shadow period on sync
    logic step;    // prescaled count step
  } tbStrobe_t;

  localparam logic [1:0] SYNC_PASS = 2'd0;
  localparam logic [1:0] SYNC_ZERO = 2'd1;
  localparam logic [1:0] SOC_ZERO  = 2'b01;
  localparam logic [1:0] SOC_PEAK  = 2'b10;

endpackage

// File: rtl/pwm_timebase_ctrl.sv
module pwm_timebase_ctrl
  import pwm_timebase_pkg::*;
#(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] cfgClkDiv,
  input  logic             cfgPhaseEn,
  input  logic [1:0]       cfgSyncOutSel,
  input  logic             ctrWrEn,
  input  logic             syncIn,
  input  logic [1:0]       statusClr,
  input  logic             zeroNext,
  input  logic             maxNext,
  output tbStrobe_t        strobe,
  output logic             syncOut,
  output logic             ctrMaxFlag,
  output logic             syncFlag
);

  localparam int PW = (1 << DIV_W) - 1;

  logic [PW-1:0] prescCnt;
  logic [PW:0]   maskWide;
  logic [PW-1:0] mask;
  logic          tick;

  always_comb begin
    maskWide = ((PW+1)'(1) << cfgClkDiv) - (PW+1)'(1);
    mask     = maskWide[PW-1:0];
    tick     = (prescCnt & mask) == mask;
  end

  always_comb begin
    strobe.wr     = ctrWrEn;
    strobe.load   = syncIn && cfgPhaseEn && !ctrWrEn;
    strobe.shadow = syncIn && !ctrWrEn;
    strobe.step   = tick && !ctrWrEn && !strobe.load;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescCnt   <= '0;
      syncOut    <= 1'b0;
      ctrMaxFlag <= 1'b0;
      syncFlag   <= 1'b0;
    end else begin
      if (strobe.wr || strobe.load) prescCnt <= '0;
      else                          prescCnt <= prescCnt + 1'b1;

      case (cfgSyncOutSel)
        SYNC_PASS: syncOut <= syncIn;
        SYNC_ZERO: syncOut <= zeroNext;
        default:   syncOut <= 1'b0;
      endcase

      if (maxNext)           ctrMaxFlag <= 1'b1;
      else if (statusClr[0]) ctrMaxFlag <= 1'b0;

      if (syncIn)            syncFlag <= 1'b1;
      else if (statusClr[1]) syncFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/pwm_timebase_dp.sv
module pwm_timebase_dp
  import pwm_timebase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tbStrobe_t        strobe,
  input  logic [CNT_W-1:0] cfgPeriod,
  input  logic [CNT_W-1:0] cfgPhase,
  input  logic [CNT_W-1:0] ctrWrData,
  output logic [CNT_W-1:0] counter,
  output logic             dirUp,
  output logic [CNT_W-1:0] activePeriod,
  output logic             zeroEvt,
  output logic             periodEvt,
  output logic             zeroNext,
  output logic             maxNext
);

  logic [CNT_W-1:0] effPer;
  logic [CNT_W-1:0] stepVal;
  logic             atZero;
  logic             goUp;
  logic             stepUp;
  logic             peakNext;

  always_comb begin
    atZero   = counter == '0;
    // a new cycle starts when stepping off zero: take the shadow value then
    effPer   = atZero ? cfgPeriod : activePeriod;
    goUp     = dirUp ? (counter < effPer || atZero) : atZero;
    stepVal  = goUp ? counter + 1'b1 : counter - 1'b1;
    stepUp   = goUp ? (stepVal < effPer) : (stepVal == '0);
    peakNext = strobe.step && goUp && (stepVal == effPer);
    // a load onto zero counts as reaching zero unless already there
    zeroNext = (strobe.step && !goUp && stepVal == '0) ||
               (strobe.load && cfgPhase == '0 && !atZero);
    maxNext  = strobe.step && goUp && (stepVal == '1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      counter      <= '0;
      dirUp        <= 1'b1;
      activePeriod <= '0;
      zeroEvt      <= 1'b0;
      periodEvt    <= 1'b0;
    end else begin
      if (strobe.wr) begin
        counter <= ctrWrData;
      end else if (strobe.load) begin
        counter <= cfgPhase;
        dirUp   <= 1'b1;
      end else if (strobe.step) begin
        counter <= stepVal;
        dirUp   <= stepUp;
      end

      if (strobe.shadow || (strobe.step && atZero)) activePeriod <= cfgPeriod;

      zeroEvt   <= zeroNext;
      periodEvt <= peakNext;
    end
  end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_timebase_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 3,
  parameter int SOC_CH = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CNT_W-1:0]    cfgPeriod,
  input  logic [CNT_W-1:0]    cfgPhase,
  input  logic                cfgPhaseEn,
  input  logic [1:0]          cfgSyncOutSel,
  input  logic [DIV_W-1:0]    cfgClkDiv,
  input  logic [SOC_CH-1:0]   socEn,
  input  logic [2*SOC_CH-1:0] socSel,
  input  logic                ctrWrEn,
  input  logic [CNT_W-1:0]    ctrWrData,
  input  logic [1:0]          statusClr,
  input  logic                syncIn,
  output logic [CNT_W-1:0]    counter,
  output logic                dirUp,
  output logic                zeroEvt,
  output logic                periodEvt,
  output logic [SOC_CH-1:0]   socPulse,
  output logic                syncOut,
  output logic                ctrMaxFlag,
  output logic                syncFlag
);

  tbStrobe_t        strobe;
  logic             zeroNext;
  logic             maxNext;
  logic [CNT_W-1:0] activePeriod;

  pwm_timebase_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgClkDiv(cfgClkDiv), .cfgPhaseEn(cfgPhaseEn),
    .cfgSyncOutSel(cfgSyncOutSel), .ctrWrEn(ctrWrEn), .syncIn(syncIn),
    .statusClr(statusClr), .zeroNext(zeroNext), .maxNext(maxNext),
    .strobe(strobe), .syncOut(syncOut), .ctrMaxFlag(ctrMaxFlag),
    .syncFlag(syncFlag)
  );

  pwm_timebase_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgPeriod(cfgPeriod),
    .cfgPhase(cfgPhase), .ctrWrData(ctrWrData), .counter(counter),
    .dirUp(dirUp), .activePeriod(activePeriod), .zeroEvt(zeroEvt),
    .periodEvt(periodEvt), .zeroNext(zeroNext), .maxNext(maxNext)
  );

  for (genvar g = 0; g < SOC_CH; g++) begin : g_soc
    logic [1:0] sel;
    assign sel = socSel[2*g +: 2];
    assign socPulse[g] = socEn[g] &&
                         ((sel == SOC_ZERO && zeroEvt) || (sel == SOC_PEAK && periodEvt));
  end

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
  parameter int CNT_W  = 16,
  parameter int SOC_CH = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [CNT_W-1:0]  cfgPhase,
  input logic              cfgPhaseEn,
  input logic [1:0]        cfgSyncOutSel,
  input logic              ctrWrEn,
  input logic [CNT_W-1:0]  ctrWrData,
  input logic              syncIn,
  input logic [CNT_W-1:0]  counter,
  input logic              dirUp,
  input logic [CNT_W-1:0]  activePeriod,
  input logic              zeroEvt,
  input logic              periodEvt,
  input logic [SOC_CH-1:0] socPulse,
  input logic              syncOut,
  input logic              syncFlag
);

  p_zero_cnt_r3: assert property (@(posedge clk) disable iff (!rstN)
    zeroEvt |-> counter == '0);

  p_peak_cnt_r3: assert property (@(posedge clk) disable iff (!rstN)
    periodEvt |-> counter == activePeriod);

  p_small_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrWrEn && !(syncIn && cfgPhaseEn)) |=>
      (counter == $past(counter) + 1'b1 || counter == $past(counter) - 1'b1 ||
       counter == $past(counter)));

  p_phase_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    (syncIn && cfgPhaseEn && !ctrWrEn) |=> counter == $past(cfgPhase));

  p_dir_up_r7: assert property (@(posedge clk) disable iff (!rstN)
    (syncIn && cfgPhaseEn && !ctrWrEn) |=> dirUp);

  p_sync_pass_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSyncOutSel == 2'd0) |=> syncOut == $past(syncIn));

  p_sync_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSyncOutSel[1]) |=> !syncOut);

  p_no_double_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    zeroEvt |=> !zeroEvt);

  p_sync_flag_r11: assert property (@(posedge clk) disable iff (!rstN)
    syncIn |=> syncFlag);

  p_write_r12: assert property (@(posedge clk) disable iff (!rstN)
    ctrWrEn |=> counter == $past(ctrWrData));

  for (genvar g = 0; g < SOC_CH; g++) begin : g_chk
    p_soc_evt_r10: assert property (@(posedge clk) disable iff (!rstN)
      socPulse[g] |-> (zeroEvt || periodEvt));
  end

endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W), .SOC_CH(SOC_CH)) u_chk (
  .clk(clk), .rstN(rstN), .cfgPhase(cfgPhase), .cfgPhaseEn(cfgPhaseEn),
  .cfgSyncOutSel(cfgSyncOutSel), .ctrWrEn(ctrWrEn), .ctrWrData(ctrWrData),
  .syncIn(syncIn), .counter(counter), .dirUp(dirUp), .activePeriod(activePeriod),
  .zeroEvt(zeroEvt), .periodEvt(periodEvt), .socPulse(socPulse),
  .syncOut(syncOut), .syncFlag(syncFlag)
);

// File: tb/pwm_timebase_tb.sv
module pwm_timebase_tb;

  localparam int CNT_W = 16;
  localparam int DIV_W = 3;
  localparam int SOC_CH = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CNT_W-1:0] cfgPeriod = 16'd5;
  logic [CNT_W-1:0] cfgPhase = '0;
  logic cfgPhaseEn = 1'b0;
  logic [1:0] cfgSyncOutSel = 2'd2;
  logic [DIV_W-1:0] cfgClkDiv = '0;
  logic [SOC_CH-1:0] socEn = '0;
  logic [2*SOC_CH-1:0] socSel = '0;
  logic ctrWrEn = 1'b0;
  logic [CNT_W-1:0] ctrWrData = '0;
  logic [1:0] statusClr = '0;
  logic syncIn = 1'b0;

  logic [CNT_W-1:0] counter, sCounter;
  logic dirUp, zeroEvt, periodEvt, syncOut, ctrMaxFlag, syncFlag;
  logic sDirUp, sZeroEvt, sPeriodEvt, sSyncOut, sCtrMaxFlag, sSyncFlag;
  logic [SOC_CH-1:0] socPulse, sSocPulse;

  always #5 clk = ~clk;

  pwm_timebase #(.CNT_W(CNT_W), .DIV_W(DIV_W), .SOC_CH(SOC_CH)) u_dut (
    .clk(clk), .rstN(rstN), .cfgPeriod(cfgPeriod), .cfgPhase(cfgPhase),
    .cfgPhaseEn(cfgPhaseEn), .cfgSyncOutSel(cfgSyncOutSel), .cfgClkDiv(cfgClkDiv),
    .socEn(socEn), .socSel(socSel), .ctrWrEn(ctrWrEn), .ctrWrData(ctrWrData),
    .statusClr(statusClr), .syncIn(syncIn), .counter(counter), .dirUp(dirUp),
    .zeroEvt(zeroEvt), .periodEvt(periodEvt), .socPulse(socPulse),
    .syncOut(syncOut), .ctrMaxFlag(ctrMaxFlag), .syncFlag(syncFlag)
  );

  // slave timebase retimed by the master's sync output
  pwm_timebase #(.CNT_W(CNT_W), .DIV_W(DIV_W), .SOC_CH(SOC_CH)) u_slave (
    .clk(clk), .rstN(rstN), .cfgPeriod(cfgPeriod), .cfgPhase('0),
    .cfgPhaseEn(1'b1), .cfgSyncOutSel(2'd0), .cfgClkDiv('0),
    .socEn('0), .socSel('0), .ctrWrEn(1'b0), .ctrWrData('0),
    .statusClr(2'b00), .syncIn(syncOut), .counter(sCounter), .dirUp(sDirUp),
    .zeroEvt(sZeroEvt), .periodEvt(sPeriodEvt), .socPulse(sSocPulse),
    .syncOut(sSyncOut), .ctrMaxFlag(sCtrMaxFlag), .syncFlag(sSyncFlag)
  );

  int total = 0;
  int bad = 0;
  bit doneFlag = 0;

  task automatic chkEq(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic endRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    endRun();
  end

  // scoreboard: expected per-cycle items, popped 2 ns after each edge
  typedef struct {
    int    cnt;
    bit    z;
    bit    p;
    string req;
  } expItem_t;
  expItem_t sbQ[$];

  always @(posedge clk) begin
    #2;
    if (sbQ.size() > 0) begin
      expItem_t it;
      it = sbQ.pop_front();
      chkEq(it.req, "sb counter", counter, it.cnt);
      chkEq("R3", "sb zeroEvt", zeroEvt, it.z);
      chkEq("R3", "sb periodEvt", periodEvt, it.p);
    end
  end

  task automatic pushCycle(int per, int nCyc, string req);
    for (int k = 1; k <= nCyc; k++) begin
      expItem_t it;
      int m;
      m = k % (2 * per);
      it.cnt = (m <= per) ? m : 2 * per - m;
      it.z = (it.cnt == 0);
      it.p = (it.cnt == per);
      it.req = req;
      sbQ.push_back(it);
    end
  endtask

  // chain monitor for R13
  bit chainOn = 0;
  int mZc, mPc, sZc, sPc, mViol, sViol;
  bit mLastPeak, sLastPeak;

  always @(posedge clk) begin
    #2;
    if (chainOn) begin
      if (zeroEvt)    begin if (!mLastPeak) mViol++; mLastPeak = 0; mZc++; end
      if (periodEvt)  begin if (mLastPeak)  mViol++; mLastPeak = 1; mPc++; end
      if (sZeroEvt)   begin if (!sLastPeak) sViol++; sLastPeak = 0; sZc++; end
      if (sPeriodEvt) begin if (sLastPeak)  sViol++; sLastPeak = 1; sPc++; end
    end
  end

  task automatic doReset();
    rstN = 1'b0;
    ctrWrEn = 1'b0;
    syncIn = 1'b0;
    statusClr = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  int c0, c1;

  initial begin
    // R1 reset state
    cfgPeriod = 16'd5;
    doReset();
    chkEq("R1", "counter", counter, 0);
    chkEq("R1", "dirUp", dirUp, 1);
    chkEq("R1", "events", {zeroEvt, periodEvt, syncOut}, 0);
    chkEq("R1", "flags", {ctrMaxFlag, syncFlag, socPulse}, 0);

    // R2/R3 scoreboard, period 5 then period 1
    pushCycle(5, 12, "R2");
    cyc(12);
    cfgPeriod = 16'd1;
    doReset();
    pushCycle(1, 6, "R2");
    cyc(7);

    // R5 prescaler divide by 4
    cfgPeriod = 16'd20;
    cfgClkDiv = 3'd2;
    doReset();
    cyc(3);
    chkEq("R5", "before 4th clock", counter, 0);
    cyc(1);
    chkEq("R5", "at 4th clock", counter, 1);
    cyc(3);
    chkEq("R5", "at 7th clock", counter, 1);
    cyc(1);
    chkEq("R5", "at 8th clock", counter, 2);
    cfgClkDiv = '0;

    // R4 shadow period taken at next cycle start
    cfgPeriod = 16'd4;
    doReset();
    cyc(2);
    cfgPeriod = 16'd6;
    cyc(2);
    chkEq("R4", "old peak value", counter, 4);
    chkEq("R4", "old peak event", periodEvt, 1);
    cyc(4);
    chkEq("R4", "zero", counter, 0);
    chkEq("R3", "zero event", zeroEvt, 1);
    cyc(6);
    chkEq("R4", "new peak value", counter, 6);
    chkEq("R4", "new peak event", periodEvt, 1);

    // R6/R7/R8 phase load, pass-through sync out
    cfgPeriod = 16'd10;
    cfgPhase = 16'd3;
    cfgPhaseEn = 1'b1;
    cfgSyncOutSel = 2'd0;
    doReset();
    cyc(7);
    syncIn = 1'b1;
    cyc(1);
    syncIn = 1'b0;
    chkEq("R6", "loaded phase", counter, 3);
    chkEq("R8", "pass syncOut", syncOut, 1);
    cyc(1);
    chkEq("R7", "rises after load", counter, 4);
    chkEq("R8", "pass syncOut end", syncOut, 0);
    cyc(9);
    chkEq("R2", "falling value", counter, 7);
    chkEq("R7", "falling dir", dirUp, 0);
    syncIn = 1'b1;
    cyc(1);
    syncIn = 1'b0;
    chkEq("R6", "load while falling", counter, 3);
    cyc(1);
    chkEq("R7", "up after load while falling", counter, 4);

    // R6 no load when disabled, R8 sync out off, R11 flag set
    cfgPhaseEn = 1'b0;
    cfgSyncOutSel = 2'd2;
    doReset();
    cyc(7);
    syncIn = 1'b1;
    cyc(1);
    syncIn = 1'b0;
    chkEq("R6", "no load when disabled", counter, 8);
    chkEq("R8", "syncOut off", syncOut, 0);
    chkEq("R11", "syncFlag set", syncFlag, 1);

    // R9 zero event on sync load, no double at zero, R8 zero select
    cfgPhase = 16'd0;
    cfgPhaseEn = 1'b1;
    cfgSyncOutSel = 2'd1;
    doReset();
    cyc(5);
    syncIn = 1'b1;
    cyc(1);
    syncIn = 1'b0;
    chkEq("R9", "load to zero value", counter, 0);
    chkEq("R9", "load to zero event", zeroEvt, 1);
    chkEq("R8", "zero-select syncOut", syncOut, 1);
    cyc(1);
    chkEq("R9", "single pulse", zeroEvt, 0);
    chkEq("R7", "rise after zero load", counter, 1);
    cyc(19);
    chkEq("R9", "natural zero", zeroEvt, 1);
    syncIn = 1'b1;
    cyc(1);
    syncIn = 1'b0;
    chkEq("R9", "no second pulse value", counter, 0);
    chkEq("R9", "no second pulse", zeroEvt, 0);
    cyc(1);
    chkEq("R9", "leaves zero", counter, 1);

    // R10 start-of-conversion channels
    cfgPhaseEn = 1'b0;
    cfgSyncOutSel = 2'd2;
    cfgPeriod = 16'd3;
    socEn = 2'b11;
    socSel = {2'b10, 2'b01};
    doReset();
    c0 = 0; c1 = 0;
    for (int k = 0; k < 12; k++) begin
      cyc(1);
      c0 += socPulse[0];
      c1 += socPulse[1];
    end
    chkEq("R10", "zero-select pulses", c0, 2);
    chkEq("R10", "period-select pulses", c1, 2);
    socEn = 2'b01;
    socSel = {2'b10, 2'b11};
    c0 = 0; c1 = 0;
    for (int k = 0; k < 12; k++) begin
      cyc(1);
      c0 += socPulse[0];
      c1 += socPulse[1];
    end
    chkEq("R10", "select 11 pulses", c0, 0);
    chkEq("R10", "disabled channel pulses", c1, 0);
    socEn = '0;

    // R11 flags, R12 direct write
    cfgPeriod = 16'hFFFF;
    doReset();
    cyc(1);
    ctrWrEn = 1'b1;
    ctrWrData = 16'hFFFD;
    cyc(1);
    ctrWrEn = 1'b0;
    chkEq("R12", "written value", counter, 16'hFFFD);
    chkEq("R12", "no event on write", {zeroEvt, periodEvt}, 0);
    cyc(2);
    chkEq("R11", "all ones", counter, 16'hFFFF);
    chkEq("R11", "ctrMaxFlag set", ctrMaxFlag, 1);
    syncIn = 1'b1;
    statusClr = 2'b01;
    cyc(1);
    chkEq("R11", "ctrMaxFlag cleared", ctrMaxFlag, 0);
    chkEq("R11", "syncFlag set", syncFlag, 1);
    statusClr = 2'b10;
    cyc(1);
    chkEq("R11", "set wins over clear", syncFlag, 1);
    syncIn = 1'b0;
    cyc(1);
    chkEq("R11", "syncFlag cleared", syncFlag, 0);
    statusClr = 2'b00;
    ctrWrEn = 1'b1;
    ctrWrData = 16'd100;
    cyc(1);
    ctrWrEn = 1'b0;
    chkEq("R12", "write while falling", counter, 100);
    cyc(1);
    chkEq("R12", "direction kept", counter, 99);

    // R13 master and slave chain with period changed on the fly
    cfgPeriod = 16'd7;
    cfgSyncOutSel = 2'd1;
    doReset();
    mZc = 0; mPc = 0; sZc = 0; sPc = 0; mViol = 0; sViol = 0;
    mLastPeak = 0; sLastPeak = 0;
    chainOn = 1;
    cyc(800);
    while (!(counter == 2 && dirUp)) cyc(1);
    cfgPeriod = 16'd11;
    cyc(800);
    while (!(counter == 2 && dirUp)) cyc(1);
    cfgPeriod = 16'd4;
    cyc(800);
    chainOn = 0;
    chkEq("R13", "master alternation errors", mViol, 0);
    chkEq("R13", "slave alternation errors", sViol, 0);
    chkEq("R13", "master zero-period gap le 1", (mZc - mPc) * (mZc - mPc) <= 1, 1);
    chkEq("R13", "slave zero-period gap le 1", (sZc - sPc) * (sZc - sPc) <= 1, 1);
    chkEq("R13", "slave vs master zeros le 1", (sZc - mZc) * (sZc - mZc) <= 1, 1);
    chkEq("R13", "enough slave zero events", sZc > 100, 1);

    endRun();
  end

endmodule